// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit-Manipulation Unit

This unit carries out the single-register operations found on the second opcode page of a small 8-bit processor. It takes an operand byte, the current carry flag, a four-bit operation code and a bit index. One clock edge later it presents the new byte, four flag values (zero, subtract, half-carry, carry), a four-bit mask saying which of those flags the register file should overwrite, and an enable saying whether the byte should be written back at all.

The operation family has eight shift and rotate kinds and three single-bit operations. The shift and rotate kinds are: circular rotates both ways, rotates both ways through the carry flag, a left shift, a sign-keeping right shift, a zero-filling right shift, and a nibble exchange. The single-bit operations are test, clear and set. Each has its own carry source and its own flag-update rule. Opcode decoding and any memory-operand sequencing are left to the surrounding core. That core drives `op_sel` straight from its decoder and applies `flag_wmask` and `result_we` when it retires the operation.

Top module: `cb_shift_bit_unit`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs become zero after that edge, even if `in_valid` is also high.
- R2: An operation sampled with `in_valid` high at an edge shows its results and `out_valid`=1 right after that edge. With `in_valid` low, `out_valid` drops to 0 and the result, flags, mask and enable keep their previous values.
- R3: Code 0 (rotate left circular) moves bit 7 into bit 0 and into C. Code 1 (rotate right circular) moves bit 0 into bit 7 and into C.
- R4: Code 2 (rotate left through carry) puts the incoming carry into bit 0 and bit 7 into C. Code 3 (rotate right through carry) puts the incoming carry into bit 7 and bit 0 into C.
- R5: Code 4 (left shift) fills bit 0 with zero and puts bit 7 into C. Code 5 (arithmetic right shift) keeps bit 7 and puts bit 0 into C. Code 7 (logical right shift) fills bit 7 with zero and puts bit 0 into C.
- R6: Code 6 exchanges the upper and lower nibbles and returns C=0.
- R7: For codes 0 to 7, Z is 1 exactly when the 8-bit result is zero, N=H=0, `flag_wmask`=4'b1111, and `result_we`=1.
- R8: Code 8 (bit test) returns the operand unchanged with `result_we`=0. It gives Z = inverse of the selected bit, N=0, H=1 and C=0, with `flag_wmask`=4'b1110, so C is not written.
- R9: Code 9 clears and code 10 sets the bit chosen by `bit_idx`. All other bits are unchanged, `result_we`=1, and `flag_wmask`=0.
- R10: Codes 11 to 15 return the operand unchanged with `result_we`=0 and `flag_wmask`=0.
- R11: A flag output whose mask bit is 0 reads 0. The mask bit order is Z=bit 3, N=bit 2, H=bit 1, C=bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| op_sel | input | 4 | Operation code, 0 to 10 defined |
| bit_idx | input | 3 | Bit position for test, clear and set |
| operand | input | 8 | Source byte |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result registers hold a fresh operation |
| result | output | 8 | Produced byte |
| flag_z | output | 1 | Zero flag value |
| flag_n | output | 1 | Subtract flag value |
| flag_h | output | 1 | Half-carry flag value |
| flag_c | output | 1 | Carry flag value |
| flag_wmask | output | 4 | Flags to be written: Z, N, H, C from bit 3 down |
| result_we | output | 1 | Byte should be written back |

## Verification
Two events can land on the same edge: a reset and the capture of a valid operation. The bench drives `rst` and `in_valid` high together with an operand whose result would be non-zero, then expects every output to be zero. A second pairing is the carry input and Z. The through-carry rotates are swept with both carry values over every operand, so that cases where the carry turns a zero input into a non-zero result, and an input of 8'h80 into a zero result, are both judged against arithmetic expectations.

// File: rtl/cb_unit_pkg.sv
`timescale 1ns/1ps
package cb_unit_pkg;
  localparam int unsigned OPC_W = 4;
  localparam int unsigned FLAGS = 4;

  typedef enum logic [OPC_W-1:0] {
    CB_ROL_CIRC  = 4'd0,
    CB_ROR_CIRC  = 4'd1,
    CB_ROL_THRU  = 4'd2,
    CB_ROR_THRU  = 4'd3,
    CB_SHL       = 4'd4,
    CB_SHR_SIGN  = 4'd5,
    CB_NIB_SWAP  = 4'd6,
    CB_SHR_ZERO  = 4'd7,
    CB_BIT_TEST  = 4'd8,
    CB_BIT_CLR   = 4'd9,
    CB_BIT_SET   = 4'd10
  } cb_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } cb_flags_t;

  localparam logic [FLAGS-1:0] MASK_ALL   = 4'b1111;
  localparam logic [FLAGS-1:0] MASK_NO_C  = 4'b1110;
  localparam logic [FLAGS-1:0] MASK_NONE  = 4'b0000;
endpackage

// File: rtl/cb_shift_core.sv
`timescale 1ns/1ps
module cb_shift_core #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] opnd,
  input  logic         cin,
  input  logic [2:0]   kind,
  output logic [W-1:0] res,
  output logic         cout
);
  localparam int unsigned HALF = W / 2;

  always_comb begin
    res  = opnd;
    cout = 1'b0;
    unique case (kind)
      3'd0: begin res = {opnd[W-2:0], opnd[W-1]};      cout = opnd[W-1]; end
      3'd1: begin res = {opnd[0], opnd[W-1:1]};        cout = opnd[0];   end
      3'd2: begin res = {opnd[W-2:0], cin};            cout = opnd[W-1]; end
      3'd3: begin res = {cin, opnd[W-1:1]};            cout = opnd[0];   end
      3'd4: begin res = {opnd[W-2:0], 1'b0};           cout = opnd[W-1]; end
      3'd5: begin res = {opnd[W-1], opnd[W-1:1]};      cout = opnd[0];   end
      3'd6: begin res = {opnd[HALF-1:0], opnd[W-1:HALF]}; cout = 1'b0;   end
      default: begin res = {1'b0, opnd[W-1:1]};        cout = opnd[0];   end
    endcase
  end
endmodule

// File: rtl/cb_bit_core.sv
`timescale 1ns/1ps
module cb_bit_core #(
  parameter int unsigned W     = 8,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     opnd,
  input  logic [IDX_W-1:0] idx,
  output logic             picked,
  output logic [W-1:0]     cleared,
  output logic [W-1:0]     raised
);
  logic [W-1:0] onehot;

  for (genvar i = 0; i < W; i++) begin : g_sel
    assign onehot[i]  = (idx == IDX_W'(i));
    assign cleared[i] = opnd[i] & ~onehot[i];
    assign raised[i]  = opnd[i] |  onehot[i];
  end

  assign picked = |(opnd & onehot);
endmodule

// File: rtl/cb_shift_bit_unit.sv
`timescale 1ns/1ps
module cb_shift_bit_unit
  import cb_unit_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [3:0]       op_sel,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic [W-1:0]     operand,
  input  logic             carry_in,
  output logic             out_valid,
  output logic [W-1:0]     result,
  output logic             flag_z,
  output logic             flag_n,
  output logic             flag_h,
  output logic             flag_c,
  output logic [3:0]       flag_wmask,
  output logic             result_we
);
  logic [W-1:0] sh_res;
  logic         sh_cout;
  logic         bt_pick;
  logic [W-1:0] bt_clr;
  logic [W-1:0] bt_set;

  cb_shift_core #(.W(W)) u_shift (
    .opnd (operand),
    .cin  (carry_in),
    .kind (op_sel[2:0]),
    .res  (sh_res),
    .cout (sh_cout)
  );

  cb_bit_core #(.W(W), .IDX_W(IDX_W)) u_bit (
    .opnd    (operand),
    .idx     (bit_idx),
    .picked  (bt_pick),
    .cleared (bt_clr),
    .raised  (bt_set)
  );

  logic [W-1:0]     nxt_res;
  cb_flags_t        nxt_flg;
  logic [FLAGS-1:0] nxt_mask;
  logic             nxt_we;

  always_comb begin
    nxt_res  = operand;
    nxt_flg  = '0;
    nxt_mask = MASK_NONE;
    nxt_we   = 1'b0;
    if (!op_sel[3]) begin
      nxt_res   = sh_res;
      nxt_flg.z = (sh_res == '0);
      nxt_flg.c = sh_cout;
      nxt_mask  = MASK_ALL;
      nxt_we    = 1'b1;
    end else begin
      case (op_sel)
        CB_BIT_TEST: begin
          nxt_flg.z = ~bt_pick;
          nxt_flg.h = 1'b1;
          nxt_mask  = MASK_NO_C;
        end
        CB_BIT_CLR: begin
          nxt_res = bt_clr;
          nxt_we  = 1'b1;
        end
        CB_BIT_SET: begin
          nxt_res = bt_set;
          nxt_we  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  cb_flags_t flg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      result     <= '0;
      flg_q      <= '0;
      flag_wmask <= '0;
      result_we  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= nxt_res;
        flg_q      <= nxt_flg;
        flag_wmask <= nxt_mask;
        result_we  <= nxt_we;
      end
    end
  end

  assign flag_z = flg_q.z;
  assign flag_n = flg_q.n;
  assign flag_h = flg_q.h;
  assign flag_c = flg_q.c;

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && flag_wmask == '0 && !result_we));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !$past(rst)) |=> ($stable(result) && $stable(flag_wmask) && !out_valid));

  // R7
  zero_from_result_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_sel[3]) |=> (flag_z == (result == '0) && !flag_n && !flag_h));

  // R8
  test_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == CB_BIT_TEST) |=> (!result_we && flag_h && !flag_wmask[0]));

  // R9
  single_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_sel == CB_BIT_CLR || op_sel == CB_BIT_SET))
      |=> ($countones(result ^ $past(operand)) <= 1 && flag_wmask == '0));

  // R11
  masked_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ({flag_z, flag_n, flag_h, flag_c} & ~flag_wmask) == '0);
endmodule

// File: tb/cb_shift_bit_unit_test.sv
`timescale 1ns/1ps
module cb_shift_bit_unit_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [3:0] op_sel;
  logic [2:0] bit_idx;
  logic [7:0] operand;
  logic       carry_in;
  logic       out_valid;
  logic [7:0] result;
  logic       flag_z, flag_n, flag_h, flag_c;
  logic [3:0] flag_wmask;
  logic       result_we;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cb_shift_bit_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .bit_idx(bit_idx), .operand(operand), .carry_in(carry_in),
    .out_valid(out_valid), .result(result), .flag_z(flag_z),
    .flag_n(flag_n), .flag_h(flag_h), .flag_c(flag_c),
    .flag_wmask(flag_wmask), .result_we(result_we)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    summary();
    $finish;
  end

  task automatic expect_all(string tag, int er, int ez, int en, int eh, int ec,
                            int em, int ewe, int ev);
    checks++;
    if (result !== 8'(er) || flag_z !== 1'(ez) || flag_n !== 1'(en) ||
        flag_h !== 1'(eh) || flag_c !== 1'(ec) || flag_wmask !== 4'(em) ||
        result_we !== 1'(ewe) || out_valid !== 1'(ev)) begin
      fails++;
      $display("FAIL %s op=%0d x=%02h ci=%0d idx=%0d: actual res=%02h znhc=%b%b%b%b m=%b we=%b v=%b expected res=%02h znhc=%0d%0d%0d%0d m=%04b we=%0d v=%0d",
               tag, op_sel, operand, carry_in, bit_idx, result, flag_z, flag_n,
               flag_h, flag_c, flag_wmask, result_we, out_valid,
               er, ez, en, eh, ec, em, ewe, ev);
    end
  endtask

  task automatic model(int op, int x, int ci, int idx, output int r, output int z,
                       output int n, output int h, output int c, output int m,
                       output int we, output string tag);
    int b;
    int p;
    p = 1 << idx;
    b = (x / p) % 2;
    r = x; z = 0; n = 0; h = 0; c = 0; m = 0; we = 0;
    case (op)
      0: begin r = (x*2)%256 + x/128; c = x/128; tag = "R3,R7"; end
      1: begin r = x/2 + (x%2)*128;   c = x%2;   tag = "R3,R7"; end
      2: begin r = (x*2)%256 + ci;    c = x/128; tag = "R4,R7"; end
      3: begin r = x/2 + ci*128;      c = x%2;   tag = "R4,R7"; end
      4: begin r = (x*2)%256;         c = x/128; tag = "R5,R7"; end
      5: begin r = x/2 + (x/128)*128; c = x%2;   tag = "R5,R7"; end
      6: begin r = (x%16)*16 + x/16;  c = 0;     tag = "R6,R7"; end
      7: begin r = x/2;               c = x%2;   tag = "R5,R7"; end
      8: begin z = 1 - b; h = 1; m = 14; tag = "R8,R11"; end
      9: begin r = x - b*p; we = 1; tag = "R9,R11"; end
      10: begin r = x + (1-b)*p; we = 1; tag = "R9,R11"; end
      default: tag = "R10,R11";
    endcase
    if (op < 8) begin
      z = (r == 0) ? 1 : 0;
      m = 15;
      we = 1;
    end
  endtask

  initial begin
    int er, ez, en, eh, ec, em, ewe;
    string tag;
    rst = 1'b1; in_valid = 1'b0; op_sel = '0; bit_idx = '0;
    operand = '0; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    expect_all("R1 reset", 0, 0, 0, 0, 0, 0, 0, 0);

    // R1: reset and a valid capture on the same edge, reset wins
    @(negedge clk);
    in_valid = 1'b1; op_sel = 4'd0; operand = 8'h81; carry_in = 1'b1;
    @(posedge clk); #1;
    expect_all("R1 reset-vs-valid", 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    rst = 1'b0;

    for (int op = 0; op < 16; op++) begin
      for (int x = 0; x < 256; x++) begin
        for (int ci = 0; ci < 2; ci++) begin
          for (int idx = 0; idx < 8; idx++) begin
            if ((op < 8 || op > 10) && idx != x % 8) continue;
            @(negedge clk);
            in_valid = 1'b1; op_sel = 4'(op); operand = 8'(x);
            carry_in = 1'(ci); bit_idx = 3'(idx);
            model(op, x, ci, idx, er, ez, en, eh, ec, em, ewe, tag);
            @(posedge clk); #1;
            expect_all(tag, er, ez, en, eh, ec, em, ewe, 1);
          end
        end
      end
    end

    // R2: capture a known result, then idle with new inputs and see it hold
    @(negedge clk);
    in_valid = 1'b1; op_sel = 4'd6; operand = 8'h3c; carry_in = 1'b0; bit_idx = 3'd0;
    @(posedge clk); #1;
    expect_all("R2 capture", 8'hc3, 0, 0, 0, 0, 15, 1, 1);
    @(negedge clk);
    in_valid = 1'b0; op_sel = 4'd8; operand = 8'h00; carry_in = 1'b1;
    @(posedge clk); #1;
    expect_all("R2 hold", 8'hc3, 0, 0, 0, 0, 15, 1, 0);
    @(posedge clk); #1;
    expect_all("R2 hold second", 8'hc3, 0, 0, 0, 0, 15, 1, 0);

    // R4: carry turns 0x80 into zero on left rotate through carry with ci=0
    @(negedge clk);
    in_valid = 1'b1; op_sel = 4'd2; operand = 8'h80; carry_in = 1'b0;
    @(posedge clk); #1;
    expect_all("R4 zero via carry", 0, 1, 0, 0, 1, 15, 1, 1);

    // R1: reset after activity clears everything
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    expect_all("R1 late reset", 0, 0, 0, 0, 0, 0, 0, 0);

    summary();
    $finish;
  end
endmodule